// File: doc/BRIEF.md
# Posted-Write Combining Buffer

This block sits on the posted-write path of a bus bridge. It accepts memory and I/O writes from the upstream side as a valid/ready stream. Each write carries a word address, a 32-bit data word, four byte enables and a space flag. Downstream it sends bursts of word beats, and the final beat of each burst carries a last flag. Memory writes are gathered into a small window of consecutive words, so several upstream writes can leave as one longer burst.

Inside the window, a write to the newest word whose byte lanes do not overlap that word's lanes is folded into the same beat. A write a short distance beyond the newest word extends the burst, and each skipped word is sent as an empty beat. No write is ever dropped or reordered against a later write to the same byte. A burst is closed and sent when any of these happens:
- the next write cannot join it;
- it fills the buffer;
- the flush input is raised;
- an I/O write is in play.

I/O writes always travel alone and unchanged.

Top module: `wcombine_buf`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: Two memory writes to the newest word of the open burst whose byte enables are disjoint leave as one beat. That beat's enables are the OR of both, and each lane carries the data of the write that enabled it. Enable bit n covers `data[8n+7:8n]`, so bit 0 is the lowest byte.
- R3: A memory write whose enables overlap those already held for the newest word is not merged. The held burst is sent first, and the later write follows in a later burst.
- R4: A memory write that lies 1 to GAP+1 words above the newest word, and still fits in DEPTH words, joins the same burst. Every skipped word is sent as a beat with enables 4'b0000.
- R5: A memory write that lies more than GAP+1 words above the newest word, or below it, closes the open burst and starts a new one.
- R6: A burst that holds DEPTH words is closed and sent without any flush.
- R7: Raising `flush` while words are held sends them as a burst. Raising `flush` with nothing held produces no output, and held words are not sent without a closing event.
- R8: An I/O write (`in_io`=1) leaves as a one-beat burst with `out_io`=1 and `out_last`=1, and it is never merged. Any held memory burst is sent before it.
- R9: Beats of one burst carry consecutive ascending word addresses, and `out_last` is 1 on the final beat only.
- R10: While `out_valid` is 1 and `out_ready` is 0, every output holds its value.
- R11: `in_ready` is 0 while a burst is being sent.
- R12: Each upstream byte write reaches downstream the same number of times and in the same order, and the final memory image matches that of the unmerged stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream write present |
| in_ready | output | 1 | Upstream write taken on this edge |
| in_waddr | input | AW | Word address of the write |
| in_data | input | 32 | Write data |
| in_be | input | 4 | Byte enables, bit 0 = lowest byte |
| in_io | input | 1 | 1 = I/O space, 0 = memory space |
| flush | input | 1 | Close and send the held burst |
| out_valid | output | 1 | Beat present |
| out_ready | input | 1 | Downstream takes the beat |
| out_waddr | output | AW | Word address of the beat |
| out_data | output | 32 | Beat data |
| out_be | output | 4 | Beat byte enables, 0 = empty lane |
| out_last | output | 1 | Final beat of the burst |
| out_io | output | 1 | Beat belongs to an I/O write |

## Verification
A write is taken at the edge where `in_valid` and `in_ready` are both high. It produces nothing downstream until a closing event is registered. That event is one of: the flush, the blocking write, a full window, or a held I/O write. The send phase begins at the edge after the event, so the first beat appears one cycle after it, and each further beat follows one cycle after the previous one is taken. The bench therefore makes no cycle-exact claims on beat timing. It samples the handshake two time units after each falling edge, lets a fixed settle window pass after every flush, and only then compares beat counts, burst lengths, empty-beat counts and the per-byte write history against its own model.

// File: rtl/wcombine_pkg.sv
package wcombine_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [LANES-1:0]  be;
    } slot_t;

    typedef enum logic {
        ST_FILL  = 1'b0,
        ST_DRAIN = 1'b1
    } phase_t;

    // Fold a new write into a held word lane by lane.
    function automatic slot_t fold_lanes(slot_t held, logic [DATA_W-1:0] d,
                                         logic [LANES-1:0] be);
        slot_t r;
        r = held;
        for (int l = 0; l < LANES; l++) begin
            if (be[l]) r.data[8*l +: 8] = d[8*l +: 8];
        end
        r.be = held.be | be;
        return r;
    endfunction

endpackage

// File: rtl/wcombine_fit.sv
module wcombine_fit
    import wcombine_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DEPTH = 8,
    parameter int GAP   = 2,
    parameter int CNT_W = 4,
    parameter int IDX_W = 3
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [AW-1:0]    base,
    input  logic [LANES-1:0] tail_be,
    input  logic [AW-1:0]    waddr,
    input  logic [LANES-1:0] be,
    input  logic             io,
    output logic             fits,
    output logic             merge,
    output logic [IDX_W-1:0] idx
);
    logic [AW-1:0] tail, step, room, offs;

    always_comb begin
        tail  = base + AW'(cnt) - AW'(1);
        step  = waddr - tail;
        room  = AW'(DEPTH) - AW'(cnt);
        offs  = waddr - base;
        idx   = offs[IDX_W-1:0];
        fits  = 1'b0;
        merge = 1'b0;
        if (cnt == '0) begin
            fits = 1'b1;
            idx  = '0;
        end else if (!io) begin
            if (step == '0) begin
                merge = 1'b1;
                fits  = ((be & tail_be) == '0);
            end else if ((waddr > tail) && (step <= AW'(GAP + 1)) && (step <= room)) begin
                fits = 1'b1;
            end
        end
    end
endmodule

// File: rtl/wcombine_store.sv
module wcombine_store
    import wcombine_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_lo,
    input  logic [IDX_W-1:0]  wr_hi,
    input  logic              wr_merge,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_be,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [IDX_W-1:0]  tail_idx,
    output slot_t             rd_slot,
    output logic [LANES-1:0]  tail_be
);
    slot_t slots [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && (IDX_W'(gi) >= wr_lo) && (IDX_W'(gi) <= wr_hi)) begin
                if (IDX_W'(gi) == wr_hi) begin
                    if (wr_merge) slots[gi] <= fold_lanes(slots[gi], wr_data, wr_be);
                    else          slots[gi] <= '{data: wr_data, be: wr_be};
                end else begin
                    slots[gi] <= '{data: '0, be: '0};
                end
            end
        end
    end

    assign rd_slot = slots[rd_idx];
    assign tail_be = slots[tail_idx].be;
endmodule

// File: rtl/wcombine_buf.sv
module wcombine_buf
    import wcombine_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DEPTH = 8,
    parameter int GAP   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [AW-1:0]     in_waddr,
    input  logic [DATA_W-1:0] in_data,
    input  logic [LANES-1:0]  in_be,
    input  logic              in_io,
    input  logic              flush,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [AW-1:0]     out_waddr,
    output logic [DATA_W-1:0] out_data,
    output logic [LANES-1:0]  out_be,
    output logic              out_last,
    output logic              out_io
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    phase_t           phase;
    logic [CNT_W-1:0] cnt;
    logic [AW-1:0]    base;
    logic             io_q;
    logic [IDX_W-1:0] rd_idx;

    logic             fits, fit_merge;
    logic [IDX_W-1:0] fit_idx;
    logic [LANES-1:0] tail_be;
    slot_t            rd_slot;
    logic             held, full, hold_close, close_req, take;
    logic [IDX_W-1:0] wr_lo, tail_idx;

    assign held       = (cnt != '0);
    assign full       = (cnt == CNT_W'(DEPTH));
    assign hold_close = held && (flush || full || io_q);
    assign close_req  = hold_close || (held && in_valid && !fits);
    assign in_ready   = (phase == ST_FILL) && fits && !hold_close;
    assign take       = in_valid && in_ready;
    assign tail_idx   = IDX_W'(cnt - CNT_W'(1));
    assign wr_lo      = !held ? '0 : (fit_merge ? tail_idx : IDX_W'(cnt));

    wcombine_fit #(
        .AW(AW), .DEPTH(DEPTH), .GAP(GAP), .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) i_fit (
        .cnt(cnt), .base(base), .tail_be(tail_be), .waddr(in_waddr),
        .be(in_be), .io(in_io), .fits(fits), .merge(fit_merge), .idx(fit_idx)
    );

    wcombine_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_store (
        .clk(clk), .wr_en(take), .wr_lo(wr_lo), .wr_hi(fit_idx),
        .wr_merge(fit_merge), .wr_data(in_data), .wr_be(in_be),
        .rd_idx(rd_idx), .tail_idx(tail_idx), .rd_slot(rd_slot), .tail_be(tail_be)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= ST_FILL;
            cnt    <= '0;
            base   <= '0;
            io_q   <= 1'b0;
            rd_idx <= '0;
        end else if (phase == ST_FILL) begin
            if (close_req) begin
                phase  <= ST_DRAIN;
                rd_idx <= '0;
            end else if (take) begin
                if (!held) begin
                    base <= in_waddr;
                    io_q <= in_io;
                end
                if (!fit_merge) cnt <= CNT_W'(fit_idx) + CNT_W'(1);
            end
        end else if (out_ready) begin
            if (out_last) begin
                phase  <= ST_FILL;
                cnt    <= '0;
                io_q   <= 1'b0;
                rd_idx <= '0;
            end else begin
                rd_idx <= rd_idx + IDX_W'(1);
            end
        end
    end

    assign out_valid = (phase == ST_DRAIN);
    assign out_waddr = base + AW'(rd_idx);
    assign out_data  = rd_slot.data;
    assign out_be    = rd_slot.be;
    assign out_last  = ((CNT_W'(rd_idx) + CNT_W'(1)) == cnt);
    assign out_io    = io_q;
endmodule

// File: rtl/wcombine_chk.sv
module wcombine_chk
    import wcombine_pkg::*;
#(
    parameter int AW = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [AW-1:0]     out_waddr,
    input logic [DATA_W-1:0] out_data,
    input logic [LANES-1:0]  out_be,
    input logic              out_last,
    input logic              out_io
);
    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_waddr) && $stable(out_data)
            && $stable(out_be) && $stable(out_last) && $stable(out_io));

    // R11
    busy_block_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    // R9
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && !out_last |=> out_valid && ((out_waddr - $past(out_waddr)) == AW'(1)));

    // R8
    io_alone_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_io |-> out_last);

    // R9
    burst_end_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && out_last |=> !out_valid);
endmodule

bind wcombine_buf wcombine_chk #(.AW(AW)) i_chk (
    .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_waddr(out_waddr), .out_data(out_data),
    .out_be(out_be), .out_last(out_last), .out_io(out_io)
);

// File: tb/test_wcombine_buf.sv
module test_wcombine_buf;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DEPTH = 8;
    localparam int GAP = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, in_io = 1'b0, flush = 1'b0, out_ready = 1'b1;
    logic [AW-1:0] in_waddr = '0;
    logic [31:0] in_data = '0;
    logic [3:0] in_be = '0;
    logic in_ready, out_valid, out_last, out_io;
    logic [AW-1:0] out_waddr;
    logic [31:0] out_data;
    logic [3:0] out_be;

    always #(CLK_PERIOD/2) clk = ~clk;

    wcombine_buf #(.AW(AW), .DEPTH(DEPTH), .GAP(GAP)) i_wcombine_buf (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_waddr(in_waddr), .in_data(in_data), .in_be(in_be), .in_io(in_io),
        .flush(flush), .out_valid(out_valid), .out_ready(out_ready),
        .out_waddr(out_waddr), .out_data(out_data), .out_be(out_be),
        .out_last(out_last), .out_io(out_io)
    );

    int n_tests = 0, n_fail = 0;
    bit bp_en = 1'b0;
    bit done = 1'b0;

    logic [7:0] hist [64][4][64];
    logic [7:0] ref_mem [64][4];
    logic [7:0] dut_mem [64][4];
    int ref_n [64][4];
    int dut_n [64][4];
    int n_beats, n_bursts, n_zero, n_io, cur_len, order_err, io_err;
    int len_log [16];
    logic [31:0] last_data;
    logic [3:0] last_be;
    logic [AW-1:0] last_addr;

    task automatic chk(string req, int act, int exp, string what);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int a = 0; a < 64; a++)
            for (int l = 0; l < 4; l++) begin
                ref_n[a][l] = 0; dut_n[a][l] = 0;
                ref_mem[a][l] = 8'h00; dut_mem[a][l] = 8'h00;
            end
        n_beats = 0; n_bursts = 0; n_zero = 0; n_io = 0; cur_len = 0;
        order_err = 0; io_err = 0;
        for (int i = 0; i < 16; i++) len_log[i] = 0;
    endtask

    // Output monitor, sampled away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (!rst && out_valid && out_ready) begin
                n_beats++;
                cur_len++;
                if (out_be == 4'b0000) n_zero++;
                if (out_io) begin
                    n_io++;
                    if (!out_last) io_err++;
                end
                last_data = out_data; last_be = out_be; last_addr = out_waddr;
                for (int l = 0; l < 4; l++) begin
                    if (out_be[l]) begin
                        automatic int a = int'(out_waddr[5:0]);
                        automatic int k = dut_n[a][l];
                        if (k >= ref_n[a][l] || hist[a][l][k] != out_data[8*l +: 8]) order_err++;
                        dut_mem[a][l] = out_data[8*l +: 8];
                        dut_n[a][l] = k + 1;
                    end
                end
                if (out_last) begin
                    if (n_bursts < 16) len_log[n_bursts] = cur_len;
                    n_bursts++;
                    cur_len = 0;
                end
            end
        end
    end

    // Downstream back-pressure
    initial begin
        forever begin
            @(negedge clk);
            out_ready = bp_en ? 1'($urandom_range(0, 1)) : 1'b1;
        end
    end

    // Called at a falling edge; returns at a falling edge
    task automatic wr(int w, logic [31:0] d, logic [3:0] be, logic io);
        in_valid = 1'b1; in_waddr = AW'(w); in_data = d; in_be = be; in_io = io;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        for (int l = 0; l < 4; l++) begin
            if (be[l]) begin
                hist[w][l][ref_n[w][l]] = d[8*l +: 8];
                ref_mem[w][l] = d[8*l +: 8];
                ref_n[w][l]++;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_flush(int settle);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        repeat (settle) @(negedge clk);
    endtask

    task automatic image_check(string tag);
        automatic int errs = order_err;
        for (int a = 0; a < 64; a++)
            for (int l = 0; l < 4; l++)
                if (ref_n[a][l] != dut_n[a][l] || ref_mem[a][l] != dut_mem[a][l]) errs++;
        chk("R12", errs, 0, {tag, " byte order and image"});
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", int'(out_valid), 0, "out_valid after reset");
        chk("R1", int'(in_ready), 1, "in_ready after reset");
    endtask

    task automatic t_merge();
        clear_model();
        wr(10, 32'h0000_00AA, 4'b0001, 1'b0);
        wr(10, 32'h0000_BB00, 4'b0010, 1'b0);
        do_flush(20);
        chk("R2", n_beats, 1, "merged beat count");
        chk("R2", int'(last_be), 4'b0011, "merged enables");
        chk("R2", int'(last_data[15:0]), 16'hBBAA, "merged lanes");
        image_check("merge");
    endtask

    task automatic t_overlap();
        clear_model();
        wr(20, 32'h0000_1111, 4'b0011, 1'b0);
        wr(20, 32'h0022_2200, 4'b0110, 1'b0);
        do_flush(20);
        chk("R3", n_bursts, 2, "overlap burst count");
        chk("R3", int'(last_be), 4'b0110, "later write last");
        image_check("overlap");
    endtask

    task automatic t_gap();
        clear_model();
        wr(30, 32'h3030_3030, 4'b1111, 1'b0);
        wr(32, 32'h3232_3232, 4'b1111, 1'b0);
        wr(35, 32'h3535_3535, 4'b1000, 1'b0);
        do_flush(30);
        chk("R4", n_bursts, 1, "gap burst count");
        chk("R4", n_beats, 6, "gap beat count");
        chk("R4", n_zero, 3, "empty beats");
        chk("R9", int'(last_addr), 35, "final beat address");
        image_check("gap");
    endtask

    task automatic t_break();
        clear_model();
        wr(40, 32'h4040_4040, 4'b1111, 1'b0);
        wr(44, 32'h4444_4444, 4'b1111, 1'b0);
        wr(43, 32'h4343_4343, 4'b1111, 1'b0);
        do_flush(30);
        chk("R5", n_bursts, 3, "far and backward burst count");
        chk("R5", n_beats, 3, "far and backward beat count");
        image_check("break");
    endtask

    task automatic t_depth();
        clear_model();
        for (int w = 0; w < 10; w++) wr(w, 32'h0101_0101 * w, 4'b1111, 1'b0);
        do_flush(30);
        chk("R6", n_bursts, 2, "bursts over depth");
        chk("R6", len_log[0], DEPTH, "first burst length");
        chk("R6", len_log[1], 10 - DEPTH, "second burst length");
        image_check("depth");
    endtask

    task automatic t_flush();
        clear_model();
        do_flush(10);
        chk("R7", n_beats, 0, "flush while empty");
        wr(5, 32'h0505_0505, 4'b1111, 1'b0);
        repeat (10) @(negedge clk);
        chk("R7", n_beats, 0, "held without closing event");
        do_flush(20);
        chk("R7", n_beats, 1, "flush sends held word");
        image_check("flush");
    endtask

    task automatic t_io();
        clear_model();
        wr(60, 32'h0000_00C1, 4'b0001, 1'b0);
        wr(60, 32'h0000_C200, 4'b0010, 1'b1);
        wr(60, 32'h00C3_0000, 4'b0100, 1'b0);
        do_flush(30);
        chk("R8", n_bursts, 3, "io split burst count");
        chk("R8", n_io, 1, "io beat count");
        chk("R8", io_err, 0, "io beat not last");
        chk("R8", len_log[0] + len_log[1] + len_log[2], 3, "single-beat bursts");
        image_check("io");
    endtask

    task automatic t_random();
        clear_model();
        bp_en = 1'b1;
        for (int i = 0; i < 40; i++) begin
            automatic int w = $urandom_range(0, 15);
            automatic logic [3:0] be = 4'($urandom_range(1, 15));
            automatic logic io = ($urandom_range(0, 7) == 0);
            wr(w, $urandom, be, io);
        end
        do_flush(200);
        bp_en = 1'b0;
        repeat (5) @(negedge clk);
        chk("R10", io_err, 0, "io beats under back-pressure");
        image_check("random back-pressure");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        clear_model();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_merge();
        t_overlap();
        t_gap();
        t_break();
        t_depth();
        t_flush();
        t_io();
        t_random();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule